// File: doc/BRIEF.md
# Four-Lane Table-Driven CRC-32 Engine

This block computes the reflected 32-bit CRC of a byte stream and takes in one 32-bit word, which is four message bytes, on every clock. The word is XORed into the running remainder. The next remainder is then the XOR of four table lookups, one per byte lane. Each lane has its own table. The tables are computed from the generator polynomial by constant functions when the design is elaborated.

A producer starts a message with `start_i`. It then streams words over a valid/ready handshake and flags the final word with `in_last_i`. A byte count marks a final word that is only partly filled. Such a word leaves the word datapath and is finished one byte per cycle on a separate single-byte update path, and the input stalls meanwhile. The inverted final remainder appears on `crc_o` together with a one-cycle `done_o` strobe. It stays there until the next start or the next result.

Top module: `crc_word_engine`

## Requirements
- R1: After reset `in_ready_o` is 1, `done_o` is 0 and `crc_o` is 0. The remainder is preset to 0xFFFFFFFF, so a first message sent without `start_i` gives the correct CRC.
- R2: `start_i` presets the remainder to 0xFFFFFFFF, and `crc_o` reads 0 in the next cycle. A word accepted in the same cycle as `start_i` is folded onto the preset value.
- R3: While no partial tail is pending, `in_ready_o` stays 1 and one word is absorbed per cycle. Bits [7:0] of `in_data_i` carry the earliest byte of the word and bits [31:24] the latest.
- R4: The CRC is reflected, with polynomial 0xEDB88320, and the result is the final remainder XOR 0xFFFFFFFF. The ASCII string "123456789" yields 0xCBF43926.
- R5: A final word with `in_bytes_i` = 0, meaning all four bytes are valid, raises `done_o` with a valid `crc_o` in the cycle after it is accepted.
- R6: A final word with `in_bytes_i` = n, where n is 1 to 3, uses only its low n bytes, lowest first. `in_ready_o` is 0 for the n cycles after acceptance. `done_o` and the result follow in cycle n+1 with `in_ready_o` back at 1.
- R7: `done_o` is high for one cycle per result. `crc_o` holds its value until the next `start_i` or the next result.
- R8: While `in_ready_o` is 0, `start_i`, `in_valid_i` and the data inputs have no effect.
- R9: Without `start_i`, a new message continues from the remainder left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Preset the remainder and clear the result |
| in_valid_i | input | 1 | Input word is valid |
| in_ready_o | output | 1 | Engine can accept a word |
| in_data_i | input | 32 | Message word, earliest byte in bits [7:0] |
| in_last_i | input | 1 | Word is the last of the message |
| in_bytes_i | input | 2 | Valid bytes of the last word (0 means four) |
| crc_o | output | 32 | Final CRC value |
| done_o | output | 1 | One-cycle strobe when `crc_o` is new |

## Verification
A `start_i` pulse clears `crc_o` one cycle later. A full final word produces `done_o` one cycle after its accepting edge. A tail of n bytes holds `in_ready_o` low for n cycles and produces `done_o` in cycle n+1. The bench drives inputs on falling edges and samples outputs on the falling edge of each of those exact cycles. It checks the stall window cycle by cycle, the strobe in its due cycle, and the hold of the result one cycle later. Expected CRCs come from a bit-serial model in the bench, run over every message length from 1 to 40 bytes and over several fixed patterns.

// File: rtl/crc_word_pkg.sv
// Shared constants and elaboration-time helpers for the word CRC engine.
// Assumes a reflected (LSB-first) 32-bit CRC with byte-wide table indices.
package crc_word_pkg;

    localparam int CRC_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int TBL_DEPTH = 1 << BYTE_W;

    // Shift a remainder through eight zero bits of a reflected CRC.
    function automatic logic [CRC_W-1:0] roll_byte(
        input logic [CRC_W-1:0] poly,
        input logic [CRC_W-1:0] r
    );
        logic [CRC_W-1:0] v;
        v = r;
        for (int b = 0; b < BYTE_W; b++) begin
            v = v[0] ? ((v >> 1) ^ poly) : (v >> 1);
        end
        return v;
    endfunction

    // Table entry: single-byte table value advanced through extra zero bytes.
    function automatic logic [CRC_W-1:0] table_entry(
        input logic [CRC_W-1:0]  poly,
        input int                advance,
        input logic [BYTE_W-1:0] idx
    );
        logic [CRC_W-1:0] v;
        v = roll_byte(poly, CRC_W'(idx));
        for (int a = 0; a < advance; a++) begin
            v = (v >> BYTE_W) ^ roll_byte(poly, CRC_W'(v[BYTE_W-1:0]));
        end
        return v;
    endfunction

endpackage

// File: rtl/crc_table.sv
// One byte-indexed lookup table, filled at elaboration from the polynomial.
// ADVANCE = 0 gives the plain single-byte table; ADVANCE = k gives entries
// carried through k more zero bytes. Purely combinational read.
module crc_table #(
    parameter logic [31:0] POLY    = 32'hEDB88320,
    parameter int          ADVANCE = 0
) (
    input  logic [crc_word_pkg::BYTE_W-1:0] idx_i,
    output logic [crc_word_pkg::CRC_W-1:0]  val_o
);
    import crc_word_pkg::*;

    logic [CRC_W-1:0] rom [TBL_DEPTH];

    // Each entry is a constant computed by the package function.
    for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_entry
        localparam logic [CRC_W-1:0] ENTRY = table_entry(POLY, ADVANCE, BYTE_W'(i));
        assign rom[i] = ENTRY;
    end

    // Table read.
    assign val_o = rom[idx_i];

endmodule

// File: rtl/crc_word_step.sv
// Full-word update: XOR the data lanes into the remainder, then combine one
// lookup per lane. Lane j (bits [8j+7:8j]) uses the table advanced by
// LANES-1-j zero bytes, so the earliest byte sees the deepest table.
// Assumes 1 <= LANES <= 4.
module crc_word_step #(
    parameter logic [31:0] POLY  = 32'hEDB88320,
    parameter int          LANES = 4
) (
    input  logic [crc_word_pkg::CRC_W-1:0]         rem_i,
    input  logic [crc_word_pkg::BYTE_W*LANES-1:0]  data_i,
    output logic [crc_word_pkg::CRC_W-1:0]         rem_o
);
    import crc_word_pkg::*;

    localparam int DATA_W = BYTE_W * LANES;

    logic [CRC_W-1:0] mixed;
    logic [CRC_W-1:0] carry;
    logic [CRC_W-1:0] lane_val [LANES];

    // Fold message bytes into the remainder.
    assign mixed = rem_i ^ CRC_W'(data_i);

    // Remainder bits not consumed by any lane shift straight through.
    if (DATA_W >= CRC_W) begin : g_full
        assign carry = '0;
    end else begin : g_part
        assign carry = mixed >> DATA_W;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        crc_table #(
            .POLY    (POLY),
            .ADVANCE (LANES - 1 - j)
        ) u_tbl (
            .idx_i (mixed[BYTE_W*j +: BYTE_W]),
            .val_o (lane_val[j])
        );
    end

    // XOR tree over all lane lookups.
    always_comb begin
        rem_o = carry;
        for (int j = 0; j < LANES; j++) begin
            rem_o = rem_o ^ lane_val[j];
        end
    end

endmodule

// File: rtl/crc_byte_step.sv
// Single-byte update used for partial tail words:
// next = (rem >> 8) ^ T[rem[7:0] ^ byte].
module crc_byte_step #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic [crc_word_pkg::CRC_W-1:0]  rem_i,
    input  logic [crc_word_pkg::BYTE_W-1:0] byte_i,
    output logic [crc_word_pkg::CRC_W-1:0]  rem_o
);
    import crc_word_pkg::*;

    logic [CRC_W-1:0] tval;

    crc_table #(
        .POLY    (POLY),
        .ADVANCE (0)
    ) u_tbl (
        .idx_i (rem_i[BYTE_W-1:0] ^ byte_i),
        .val_o (tval)
    );

    // Shift the consumed byte out and merge the lookup.
    assign rem_o = (rem_i >> BYTE_W) ^ tval;

endmodule

// File: rtl/crc_word_engine.sv
// Top of the word CRC engine. Absorbs LANES bytes per accepted word. A final
// word with fewer valid bytes is stored and finished one byte per cycle,
// lowest byte first, with ready held low. The result is registered together
// with a one-cycle done strobe. Assumes 2 <= LANES <= 4; synchronous,
// active-low reset.
module crc_word_engine #(
    parameter logic [31:0] POLY    = 32'hEDB88320,
    parameter logic [31:0] INIT    = 32'hFFFFFFFF,
    parameter logic [31:0] XOR_OUT = 32'hFFFFFFFF,
    parameter int          LANES   = 4,
    localparam int         DATA_W  = 8 * LANES,
    localparam int         CNT_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_last_i,
    input  logic [CNT_W-1:0]  in_bytes_i,
    output logic [31:0]       crc_o,
    output logic              done_o
);
    import crc_word_pkg::*;

    logic [CRC_W-1:0]  rem_q;
    logic              tail_q;
    logic [DATA_W-1:0] tail_buf_q;
    logic [CNT_W-1:0]  tail_left_q;
    logic [CRC_W-1:0]  crc_q;
    logic              done_q;

    logic [CRC_W-1:0]  base_rem;
    logic [CRC_W-1:0]  word_next;
    logic [CRC_W-1:0]  byte_next;
    logic              accept;
    logic              full_last;

    // Handshake and operand selection.
    assign in_ready_o = ~tail_q;
    assign accept     = in_valid_i & ~tail_q;
    assign full_last  = in_last_i & (in_bytes_i == '0);
    assign base_rem   = start_i ? INIT : rem_q;

    crc_word_step #(
        .POLY  (POLY),
        .LANES (LANES)
    ) u_word (
        .rem_i  (base_rem),
        .data_i (in_data_i),
        .rem_o  (word_next)
    );

    crc_byte_step #(
        .POLY (POLY)
    ) u_byte (
        .rem_i  (rem_q),
        .byte_i (tail_buf_q[BYTE_W-1:0]),
        .rem_o  (byte_next)
    );

    // Remainder, tail sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q       <= INIT;
            tail_q      <= 1'b0;
            tail_buf_q  <= '0;
            tail_left_q <= '0;
            crc_q       <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tail_q) begin
                rem_q       <= byte_next;
                tail_buf_q  <= tail_buf_q >> BYTE_W;
                tail_left_q <= tail_left_q - CNT_W'(1);
                if (tail_left_q == CNT_W'(1)) begin
                    tail_q <= 1'b0;
                    done_q <= 1'b1;
                    crc_q  <= byte_next ^ XOR_OUT;
                end
            end else begin
                if (start_i) begin
                    rem_q <= INIT;
                    crc_q <= '0;
                end
                if (accept) begin
                    if (!in_last_i) begin
                        rem_q <= word_next;
                    end else if (full_last) begin
                        rem_q  <= word_next;
                        done_q <= 1'b1;
                        crc_q  <= word_next ^ XOR_OUT;
                    end else begin
                        rem_q       <= base_rem;
                        tail_q      <= 1'b1;
                        tail_buf_q  <= in_data_i;
                        tail_left_q <= in_bytes_i;
                    end
                end
            end
        end
    end

    assign crc_o  = crc_q;
    assign done_o = done_q;

endmodule

// File: rtl/crc_word_engine_chk.sv
// Port-level protocol checks for crc_word_engine, attached by bind.
module crc_word_engine_chk #(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             in_last_i,
    input logic [CNT_W-1:0] in_bytes_i,
    input logic [31:0]      crc_o,
    input logic             done_o
);
    logic acc_full;
    logic acc_part;
    logic acc_one;

    // Accepted-word classes.
    assign acc_full = in_valid_i & in_ready_o & in_last_i & (in_bytes_i == '0);
    assign acc_part = in_valid_i & in_ready_o & in_last_i & (in_bytes_i != '0);
    assign acc_one  = in_valid_i & in_ready_o & in_last_i & (in_bytes_i == CNT_W'(1));

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && in_ready_o && !acc_full) |=> (crc_o == 32'h0));

    p_full_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_full |=> done_o);

    p_tail_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> (!in_ready_o && !done_o));

    p_one_byte_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_one |=> !in_ready_o ##1 (in_ready_o && done_o));

    p_busy_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready_o |-> !done_o);

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !acc_full) |=> !done_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (done_o || $stable(crc_o)));

endmodule

bind crc_word_engine crc_word_engine_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_last_i  (in_last_i),
    .in_bytes_i (in_bytes_i),
    .crc_o      (crc_o),
    .done_o     (done_o)
);

// File: tb/sim_crc_word_engine.sv
`timescale 1ns/1ps
// Self-checking bench: bit-serial reference model, length sweep and timing.
module sim_crc_word_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        in_ready_o;
    logic [31:0] in_data_i = '0;
    logic        in_last_i = 1'b0;
    logic [1:0]  in_bytes_i = '0;
    logic [31:0] crc_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] ref_rem = 32'hFFFFFFFF;
    logic [7:0]  msg [0:47];

    always #2.5 clk = ~clk;

    crc_word_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .in_data_i  (in_data_i),
        .in_last_i  (in_last_i),
        .in_bytes_i (in_bytes_i),
        .crc_o      (crc_o),
        .done_o     (done_o)
    );

    function automatic logic [31:0] ref_byte(input logic [31:0] r, input logic [7:0] b);
        logic [31:0] v;
        v = r ^ {24'h0, b};
        for (int k = 0; k < 8; k++) v = v[0] ? ((v >> 1) ^ 32'hEDB88320) : (v >> 1);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // mode 0: separate start pulse, 1: start with first word, 2: no start.
    // poke: drive start and junk data while the tail stalls.
    task automatic run_msg(input int len, input int mode, input bit poke);
        int nwords = (len + 3) / 4;
        int tail   = len % 4;
        logic [31:0] exp_crc;
        if (mode == 0) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(crc_o == 32'h0, "R2", crc_o, 32'h0);
        end
        if (mode != 2) ref_rem = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) ref_rem = ref_byte(ref_rem, msg[i]);
        exp_crc = ref_rem ^ 32'hFFFFFFFF;
        for (int w = 0; w < nwords; w++) begin
            in_valid_i = 1'b1;
            for (int b = 0; b < 4; b++)
                in_data_i[8*b +: 8] = (4*w + b < len) ? msg[4*w + b] : 8'($urandom);
            in_last_i  = (w == nwords - 1);
            in_bytes_i = (w == nwords - 1) ? 2'(tail) : 2'd0;
            start_i    = (mode == 1 && w == 0);
            check(in_ready_o == 1'b1, "R3", 32'(in_ready_o), 32'h1);
            @(negedge clk);
            in_valid_i = 1'b0;
            in_last_i  = 1'b0;
            start_i    = 1'b0;
        end
        if (tail == 0) begin
            check(done_o == 1'b1, "R5", 32'(done_o), 32'h1);
            check(crc_o == exp_crc, "R4", crc_o, exp_crc);
        end else begin
            for (int k = 1; k <= tail; k++) begin
                check(!in_ready_o && !done_o, "R6", {30'h0, in_ready_o, done_o}, 32'h0);
                if (poke && k == 1) begin
                    start_i    = 1'b1;
                    in_valid_i = 1'b1;
                    in_data_i  = $urandom;
                    in_last_i  = 1'b1;
                    in_bytes_i = 2'd0;
                end
                @(negedge clk);
                start_i    = 1'b0;
                in_valid_i = 1'b0;
                in_last_i  = 1'b0;
            end
            check(done_o && in_ready_o, "R6", {30'h0, in_ready_o, done_o}, 32'h3);
            check(crc_o == exp_crc, poke ? "R8" : "R6", crc_o, exp_crc);
        end
        @(negedge clk);
        check(done_o == 1'b0, "R7", 32'(done_o), 32'h0);
        check(crc_o == exp_crc, "R7", crc_o, exp_crc);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL all: watchdog expired, actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(in_ready_o == 1'b1, "R1", 32'(in_ready_o), 32'h1);
        check(done_o == 1'b0, "R1", 32'(done_o), 32'h0);
        check(crc_o == 32'h0, "R1", crc_o, 32'h0);

        // R1/R4: check string with no start, relying on the reset preset.
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        run_msg(9, 2, 1'b0);
        check(crc_o == 32'hCBF43926, "R4", crc_o, 32'hCBF43926);

        // R3/R5/R6: every length from 1 to 40, random contents.
        for (int len = 1; len <= 40; len++) begin
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
            run_msg(len, 0, 1'b0);
        end

        // R4: fixed patterns, all zero and all one bytes.
        for (int i = 0; i < 12; i++) msg[i] = 8'h00;
        run_msg(12, 0, 1'b0);
        for (int i = 0; i < 11; i++) msg[i] = 8'hFF;
        run_msg(11, 0, 1'b0);

        // R2: start together with the first word.
        for (int len = 1; len <= 9; len++) begin
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
            run_msg(len, 1, 1'b0);
        end

        // R8: start and junk words during tail stalls are ignored.
        for (int len = 5; len <= 7; len++) begin
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
            run_msg(len, 0, 1'b1);
        end

        // R9: messages continue from the previous remainder without start.
        for (int i = 0; i < 9; i++) msg[i] = 8'($urandom);
        run_msg(9, 2, 1'b0);
        for (int i = 0; i < 8; i++) msg[i] = 8'($urandom);
        run_msg(8, 2, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule